// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block runs a stream of stack-machine instructions against a bounded operand stack held in registers. Arithmetic instructions name no operands. They pop the two topmost words, combine them and push the result, so only the two memory-transfer instructions carry an address. A loader copies a word from the attached word memory onto the stack, and a storer moves the top word out to memory.

Instructions arrive one at a time over a valid/ready handshake. The unit drives a synchronous memory port whose read data returns one cycle after the read strobe. It shows the current top word and the current depth, and it reports an attempt to grow a full stack or to take from a stack that holds too little. Such an attempt is refused and leaves the stack intact. A halt instruction freezes the unit until reset.

Top module: `stack_exec_unit`

## Requirements
- R1: An instruction word is 16 bits: the opcode sits in bits [15:12] and a 12-bit memory address in bits [11:0]. The opcode codes are: load 1, store 2, add 3, subtract 4, multiply 5, halt 15. The address is used only by load and store, and it is driven on `memAddr` while their memory access lasts.
- R2: An accepted load on a stack that is not full asserts `memRdEn` with `memAddr` equal to the address for the single cycle after acceptance. The word returned on `memRdData` in the following cycle becomes the new top, visible two cycles after the acceptance edge. `instrReady` is low during those two cycles.
- R3: An accepted store on a non-empty stack removes the top word at once. In the next cycle it asserts `memWrEn` for one cycle with `memWrData` equal to the removed word and `memAddr` equal to the address. `instrReady` is low during that cycle.
- R4: Add replaces the two topmost words by their sum modulo 2^16. Depth drops by one, the result is visible the cycle after acceptance, and `instrReady` stays high.
- R5: Subtract leaves (second word from top) minus (top word) modulo 2^16, so load A, load B, subtract gives A−B.
- R6: Multiply leaves the low 16 bits of the product of the two topmost words.
- R7: A load accepted at depth 16 raises `overflowErr` for exactly the next cycle. It starts no memory access and leaves depth and contents unchanged.
- R8: A store at depth 0, or an arithmetic instruction at depth below 2, raises `underflowErr` for exactly the next cycle. It starts no memory access and leaves the stack unchanged.
- R9: An accepted halt sets `halted` from the next cycle onward. From then on `instrReady` stays low and no instruction is taken until reset.
- R10: After reset, depth is 0, `topData` is 0, `instrReady` is 1, and both error flags, `halted` and both memory strobes are 0.
- R11: An opcode not listed in R1 is accepted in one cycle and changes neither the stack nor the memory port.
- R12: `stackDepth` reports the number of words held, never above 16, and `topData` shows the top word, or 0 when the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word offered |
| instrReady | output | 1 | Unit can take an instruction this cycle |
| instrWord | input | 16 | Opcode [15:12], address [11:0] |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 12 | Memory word address |
| memWrData | output | 16 | Word to write |
| memRdData | input | 16 | Read word, valid the cycle after `memRdEn` |
| topData | output | 16 | Current top-of-stack word |
| stackDepth | output | 5 | Words currently on the stack |
| overflowErr | output | 1 | One-cycle pulse: load refused on full stack |
| underflowErr | output | 1 | One-cycle pulse: too few words for the instruction |
| halted | output | 1 | Execution stopped by halt |

## Verification
Arithmetic results and error pulses are due one cycle after the accepting edge, a load's read strobe one cycle after it, and its top word two cycles after it. A store's write strobe falls in the cycle after acceptance, while its shrunken depth already shows in that same cycle. A behavioural reference model in the bench advances on the same rising edges as the design, from the same inputs, so every due cycle is already placed in its state. All outputs are compared against it on each falling edge. Directed checks on results, memory contents and refused instructions sample on the falling edge after the unit returns to ready.

// File: rtl/stack_pkg.sv
package stack_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'h3;
  localparam logic [OPC_W-1:0] OP_SUB   = 4'h4;
  localparam logic [OPC_W-1:0] OP_MULT  = 4'h5;
  localparam logic [OPC_W-1:0] OP_HALT  = 4'hF;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_MUL = 2'd2
  } alu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_FILL  = 2'd2,
    ST_WRITE = 2'd3
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    doPush;
    logic    doPop;
    logic    doBin;
    alu_op_e aluOp;
    logic    latchAddr;
  } dp_ctrl_t;

endpackage

// File: rtl/stack_alu.sv
module stack_alu
  import stack_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] result
);

  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] product;

  assign product = {{DATA_W{1'b0}}, lhs} * {{DATA_W{1'b0}}, rhs};

  always_comb begin
    case (op)
      ALU_ADD: result = lhs + rhs;
      ALU_SUB: result = lhs - rhs;
      ALU_MUL: result = product[DATA_W-1:0];
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/stack_datapath.sv
module stack_datapath
  import stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dp_ctrl_t                     ctrl,
  input  logic [ADDR_W-1:0]            instrAddr,
  input  logic [DATA_W-1:0]            memRdData,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [DATA_W-1:0]            memWrData,
  output logic [DATA_W-1:0]            topData,
  output logic [$clog2(DEPTH+1)-1:0]   depth
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] entry [DEPTH];
  logic [CNT_W-1:0]  depthReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wrDataReg;
  logic [PTR_W-1:0]  topIdx;
  logic [PTR_W-1:0]  secIdx;
  logic [PTR_W-1:0]  pushIdx;
  logic [DATA_W-1:0] aluResult;

  assign topIdx  = PTR_W'(depthReg - CNT_W'(1));
  assign secIdx  = PTR_W'(depthReg - CNT_W'(2));
  assign pushIdx = PTR_W'(depthReg);

  stack_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (ctrl.aluOp),
    .lhs    (entry[secIdx]),
    .rhs    (entry[topIdx]),
    .result (aluResult)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) entry[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ctrl.doPush && pushIdx == PTR_W'(i))
          entry[i] <= memRdData;
        else if (ctrl.doBin && secIdx == PTR_W'(i))
          entry[i] <= aluResult;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthReg  <= '0;
      addrReg   <= '0;
      wrDataReg <= '0;
    end else begin
      if (ctrl.doPush)
        depthReg <= depthReg + CNT_W'(1);
      else if (ctrl.doPop || ctrl.doBin)
        depthReg <= depthReg - CNT_W'(1);
      if (ctrl.latchAddr) addrReg <= instrAddr;
      if (ctrl.doPop) wrDataReg <= entry[topIdx];
    end
  end

  assign memAddr   = addrReg;
  assign memWrData = wrDataReg;
  assign depth     = depthReg;
  assign topData   = (depthReg == '0) ? '0 : entry[topIdx];

  assert_depth_bound_R12: assert property (@(posedge clk) disable iff (!rstN)
    depthReg <= CNT_W'(DEPTH));

  assert_bin_shrinks_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doBin |=> depthReg == $past(depthReg) - CNT_W'(1));

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doPush |=> depthReg == $past(depthReg) + CNT_W'(1));

  assert_pop_latches_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doPop |=> wrDataReg == $past(topData));

endmodule

// File: rtl/stack_control.sv
module stack_control
  import stack_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [OPC_W-1:0] opcode,
  input  logic [CNT_W-1:0] depth,
  output logic             instrReady,
  output dp_ctrl_t         ctrl,
  output logic             memRdEn,
  output logic             memWrEn,
  output logic             overflowErr,
  output logic             underflowErr,
  output logic             halted
);

  ctrl_state_e state, nextState;
  logic accept;
  logic ovfNext, unfNext, haltNext;
  logic isFull, hasOne, hasTwo;

  assign isFull = (depth == CNT_W'(DEPTH));
  assign hasOne = (depth != '0);
  assign hasTwo = (depth >= CNT_W'(2));

  assign instrReady = (state == ST_IDLE) && !halted;
  assign accept     = instrValid && instrReady;
  assign memRdEn    = (state == ST_READ);
  assign memWrEn    = (state == ST_WRITE);

  always_comb begin
    ctrl      = '0;
    nextState = state;
    ovfNext   = 1'b0;
    unfNext   = 1'b0;
    haltNext  = halted;
    case (state)
      ST_READ:  nextState = ST_FILL;
      ST_FILL: begin
        ctrl.doPush = 1'b1;
        nextState   = ST_IDLE;
      end
      ST_WRITE: nextState = ST_IDLE;
      default: begin
        if (accept) begin
          case (opcode)
            OP_LOAD: begin
              if (isFull) ovfNext = 1'b1;
              else begin
                ctrl.latchAddr = 1'b1;
                nextState      = ST_READ;
              end
            end
            OP_STORE: begin
              if (!hasOne) unfNext = 1'b1;
              else begin
                ctrl.doPop     = 1'b1;
                ctrl.latchAddr = 1'b1;
                nextState      = ST_WRITE;
              end
            end
            OP_ADD, OP_SUB, OP_MULT: begin
              if (!hasTwo) unfNext = 1'b1;
              else begin
                ctrl.doBin = 1'b1;
                ctrl.aluOp = (opcode == OP_ADD) ? ALU_ADD :
                             (opcode == OP_SUB) ? ALU_SUB : ALU_MUL;
              end
            end
            OP_HALT: haltNext = 1'b1;
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
      halted       <= 1'b0;
    end else begin
      state        <= nextState;
      overflowErr  <= ovfNext;
      underflowErr <= unfNext;
      halted       <= haltNext;
    end
  end

  assert_load_reads_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opcode == OP_LOAD && !isFull) |=> memRdEn && !instrReady);

  assert_store_writes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opcode == OP_STORE && hasOne) |=> memWrEn && !instrReady);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |-> isFull && !memRdEn);

  assert_underflow_shallow_R8: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |-> !hasTwo && !memWrEn);

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && !instrReady);

  assert_strobes_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRdEn, memWrEn, overflowErr || underflowErr}));

endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
  import stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       instrValid,
  output logic                       instrReady,
  input  logic [OPC_W+ADDR_W-1:0]    instrWord,
  output logic                       memRdEn,
  output logic                       memWrEn,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [DATA_W-1:0]          memWrData,
  input  logic [DATA_W-1:0]          memRdData,
  output logic [DATA_W-1:0]          topData,
  output logic [$clog2(DEPTH+1)-1:0] stackDepth,
  output logic                       overflowErr,
  output logic                       underflowErr,
  output logic                       halted
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  dp_ctrl_t ctrl;

  stack_control #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .instrValid   (instrValid),
    .opcode       (instrWord[OPC_W+ADDR_W-1:ADDR_W]),
    .depth        (stackDepth),
    .instrReady   (instrReady),
    .ctrl         (ctrl),
    .memRdEn      (memRdEn),
    .memWrEn      (memWrEn),
    .overflowErr  (overflowErr),
    .underflowErr (underflowErr),
    .halted       (halted)
  );

  stack_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .instrAddr (instrWord[ADDR_W-1:0]),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .topData   (topData),
    .depth     (stackDepth)
  );

endmodule

// File: tb/test_stack_exec_unit.sv
`timescale 1ns/1ps
module test_stack_exec_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic        instrReady;
  logic [15:0] instrWord = '0;
  logic        memRdEn, memWrEn;
  logic [11:0] memAddr;
  logic [15:0] memWrData;
  logic [15:0] memRdData = '0;
  logic [15:0] topData;
  logic [4:0]  stackDepth;
  logic        overflowErr, underflowErr, halted;

  always #2.5 clk = ~clk;

  stack_exec_unit i_stack_exec_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrReady(instrReady),
    .instrWord(instrWord), .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .topData(topData),
    .stackDepth(stackDepth), .overflowErr(overflowErr), .underflowErr(underflowErr),
    .halted(halted)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;

  logic [15:0] benchMem [256];

  always @(posedge clk) begin
    if (memRdEn) memRdData <= benchMem[memAddr[7:0]];
    if (memWrEn) benchMem[memAddr[7:0]] <= memWrData;
  end

  // behavioural reference model
  int q[$];
  int ph = 0;
  bit mHalt = 0, eOvf = 0, eUnf = 0;
  int pAddr = 0, pData = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); ph = 0; mHalt = 0; eOvf = 0; eUnf = 0; pAddr = 0; pData = 0;
    end else begin
      eOvf = 0; eUnf = 0;
      case (ph)
        1: ph = 2;
        2: begin q.push_back(pData); ph = 0; end
        3: ph = 0;
        default: if (instrValid && !mHalt) begin
          int op, ad, a, b, r;
          op = int'(instrWord[15:12]);
          ad = int'(instrWord[11:0]);
          case (op)
            1: if (q.size() == 16) eOvf = 1;
               else begin pAddr = ad; pData = int'(benchMem[ad[7:0]]); ph = 1; end
            2: if (q.size() == 0) eUnf = 1;
               else begin pData = q.pop_back(); pAddr = ad; ph = 3; end
            3, 4, 5: if (q.size() < 2) eUnf = 1;
               else begin
                 b = q.pop_back(); a = q.pop_back();
                 r = (op == 3) ? a + b : (op == 4) ? a - b : a * b;
                 q.push_back(r & 16'hFFFF);
               end
            15: mHalt = 1;
            default: ;
          endcase
        end
      endcase
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && started) begin
      cmp("R9", "instrReady", int'(instrReady), int'(ph == 0 && !mHalt));
      cmp("R9", "halted", int'(halted), int'(mHalt));
      cmp("R12", "stackDepth", int'(stackDepth), q.size());
      cmp("R12", "topData", int'(topData), q.size() ? q[q.size()-1] : 0);
      cmp("R2", "memRdEn", int'(memRdEn), int'(ph == 1));
      cmp("R3", "memWrEn", int'(memWrEn), int'(ph == 3));
      if (ph == 1 || ph == 3) cmp("R1", "memAddr", int'(memAddr), pAddr);
      if (ph == 3) cmp("R3", "memWrData", int'(memWrData), pData);
      cmp("R7", "overflowErr", int'(overflowErr), int'(eOvf));
      cmp("R8", "underflowErr", int'(underflowErr), int'(eUnf));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic issue(input logic [3:0] op, input logic [11:0] ad);
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = {op, ad};
    while (!instrReady) @(negedge clk);
    @(posedge clk);
    #1 instrValid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!instrReady && !halted) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) benchMem[i] = 16'(i * 3);
    benchMem[10] = 16'd7;  benchMem[11] = 16'd5;  benchMem[12] = 16'd3;
    benchMem[13] = 16'hFFFF; benchMem[14] = 16'h1234;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    cmp("R10", "depth", int'(stackDepth), 0);
    cmp("R10", "top", int'(topData), 0);
    cmp("R10", "ready", int'(instrReady), 1);
    cmp("R10", "flags", int'({overflowErr, underflowErr, halted, memRdEn, memWrEn}), 0);
    started = 1;

    issue(4'h2, 12'd50); settle();           // R8 store on empty
    issue(4'h3, 12'd0);  settle();           // R8 add on empty
    issue(4'h1, 12'd10); issue(4'h1, 12'd11);
    issue(4'h4, 12'd0);  settle();
    cmp("R5", "7-5", int'(topData), 2);
    issue(4'h2, 12'd100); settle(); @(negedge clk);
    cmp("R3", "stored word", int'(benchMem[100]), 2);
    issue(4'h4, 12'd0); settle();            // R8 sub on empty
    issue(4'h1, 12'd10); issue(4'h1, 12'd12);
    issue(4'h5, 12'd0); settle();
    cmp("R6", "7*3", int'(topData), 21);
    issue(4'h1, 12'd13); issue(4'h3, 12'd0); settle();
    cmp("R4", "wrap add", int'(topData), 20);
    issue(4'h1, 12'd13); issue(4'h1, 12'd14);
    issue(4'h5, 12'd0); settle();
    cmp("R6", "low product", int'(topData), 16'hEDCC);
    issue(4'h2, 12'd101); settle();
    issue(4'h4, 12'd0); settle();            // R8 sub with one word
    cmp("R8", "depth kept", int'(stackDepth), 1);
    issue(4'h6, 12'hABC); issue(4'h0, 12'h000); settle();
    cmp("R11", "depth", int'(stackDepth), 1);
    cmp("R11", "top", int'(topData), 20);
    for (int k = 0; k < 15; k++) issue(4'h1, 12'd12);
    settle();
    cmp("R12", "full", int'(stackDepth), 16);
    issue(4'h1, 12'd10); settle();           // R7 overflow
    cmp("R7", "depth kept", int'(stackDepth), 16);
    cmp("R7", "top kept", int'(topData), 3);
    for (int k = 0; k < 15; k++) issue(4'h3, 12'd0);
    settle();
    cmp("R4", "sum", int'(topData), 65);
    issue(4'hF, 12'd0);
    @(negedge clk);
    instrValid = 1'b1; instrWord = {4'h1, 12'd10};
    repeat (6) @(negedge clk);
    instrValid = 1'b0;
    cmp("R9", "halted", int'(halted), 1);
    cmp("R9", "depth frozen", int'(stackDepth), 1);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule